// File: doc/BRIEF.md
# I2C Register-Array Slave with Auto-Increment

This block sits between a two-wire serial bus and a 256-byte on-chip register array. SCL is only an input. SDA is open-drain: the block can pull the line low and can never drive it high. Both lines are resynchronised into the system clock domain. START and STOP conditions are recognised by looking for an SDA edge while SCL is high. The array is reached through a plain port with an address, write data, a one-cycle write strobe and combinational read data.

A bus master selects the block with a 7-bit address. The upper four bits of that address are a fixed identifier, set by a parameter that defaults to 1010b. The lower three bits come from strap pins. The block supports four kinds of access:

- **Byte write:** the master sends a word address, then data bytes.
- **Current-address read:** the master reads at the address counter with no word-address phase.
- **Random read:** the master writes a word address, issues a repeated START, then reads.
- **Sequential read:** the master keeps reading for as long as it acknowledges each byte. The counter wraps from the top of the array back to zero.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges an address byte, by pulling SDA low in the ninth clock, only when its bits 7..4 are 1010b and its bits 3..1 equal `strap_addr`. Bit 0 of the address byte is the read flag, where 1 means read.
- R2: When the address byte does not match, the block drives no acknowledge for that byte or for any later byte until the next START. Array contents are left unchanged.
- R3: After a matching address byte with the read flag at 0, the next byte is a word address. It is sent MSB first and loads the address counter. The byte after it is written to that location. The block acknowledges every one of these bytes.
- R4: Every data byte that is received produces exactly one write strobe, and the address counter advances by one afterwards. Further bytes in the same transfer therefore go to consecutive locations.
- R5: A random read works as follows. The master writes a word address, issues a repeated START, then sends a matching address with the read flag at 1. The block returns the byte stored at that word address.
- R6: A read with no word-address phase starts at the current counter value. That value is zero after reset, and otherwise is whatever the previous access left.
- R7: Each time the master acknowledges a read byte, the counter advances by one and the block sends the byte at the new address.
- R8: The address counter wraps from 0xFF to 0x00 during a sequential read, and data keeps flowing.
- R9: After the master NACKs a read byte, SDA stays released. After a STOP, the block is idle, with SDA released, and is ready for a new transfer.
- R10: The block changes SDA only while SCL is low, and it only ever pulls SDA low (`sda_o` is 0 whenever `sda_oe` is 1).
- R11: A START or STOP in the middle of a byte abandons the transfer and clears the bit count. A partly received data byte is not written, and the next transfer is handled normally.
- R12: In reset, `sda_oe` and `mem_we` are 0 and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Level driven on SDA when enabled; always 0 |
| sda_oe | output | 1 | Pull SDA low when 1; release when 0 |
| strap_addr | input | 3 | Strap-selected low bits of the slave address |
| mem_addr | output | 8 | Array address, which is the current address counter |
| mem_wdata | output | 8 | Byte to write into the array |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Array read data at `mem_addr`, combinational |

## Verification
Four properties are checked on every cycle by the assertions:
- SDA drive changes only while the synchronised SCL is low, or on a START or STOP release.
- Each write strobe lasts one cycle and is followed by a single counter step.
- During a read, the counter moves only by +1.
- SDA is released after a STOP and in the ignore state.

Some behaviours only the bench's bus scenarios can show. These are whether the right bytes are acknowledged, the values that random, current-address and sequential reads return, the wrap at 0xFF, and the fact that a rejected address or an aborted byte leaves the array untouched.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [3:0] DEV_ID = 4'b1010,
  parameter int         SYNC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic [2:0] strap_addr,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  input  logic [7:0] mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_READ, S_SKIP} st_t;

  st_t        st;
  logic [SYNC:0] scl_p, sda_p;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic       rw;
  logic [7:0] addr;

  logic scl_s, scl_d, sda_s, sda_d;
  logic start_det, stop_det, scl_rise, scl_fall, rx_st, dev_hit;

  assign scl_s     = scl_p[SYNC-1];
  assign scl_d     = scl_p[SYNC];
  assign sda_s     = sda_p[SYNC-1];
  assign sda_d     = sda_p[SYNC];
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign rx_st     = (st == S_DEV) || (st == S_WADR) || (st == S_WDAT);
  assign dev_hit   = (sh[7:1] == {DEV_ID, strap_addr});
  assign sda_o     = 1'b0;
  assign mem_addr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p     <= '1;
      sda_p     <= '1;
      st        <= S_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      addr      <= '0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      scl_p  <= {scl_p[SYNC-1:0], scl_i};
      sda_p  <= {sda_p[SYNC-1:0], sda_i};
      mem_we <= 1'b0;
      if (mem_we) addr <= addr + 8'd1;

      if (start_det) begin
        st     <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (rx_st) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
          end
        end else if (scl_fall && bitcnt == 4'd8) begin
          case (st)
            S_DEV: begin
              if (dev_hit) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
              end else begin
                st     <= S_SKIP;
                bitcnt <= '0;
              end
            end
            S_WADR: begin
              sda_oe <= 1'b1;
              addr   <= sh;
            end
            default: begin
              sda_oe    <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= sh;
            end
          endcase
        end else if (scl_fall && bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (st == S_DEV && rw) begin
            st     <= S_READ;
            tx     <= mem_rdata[6:0];
            sda_oe <= ~mem_rdata[7];
          end else begin
            sda_oe <= 1'b0;
            st     <= (st == S_DEV) ? S_WADR : S_WDAT;
          end
        end
      end else if (st == S_READ) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            if (!sda_s) begin
              addr   <= addr + 8'd1;
              bitcnt <= 4'd9;
            end else begin
              st     <= S_SKIP;
              bitcnt <= '0;
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            tx     <= mem_rdata[6:0];
            sda_oe <= ~mem_rdata[7];
          end else if (bitcnt != 4'd0) begin
            tx     <= {tx[5:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R10

  AST_WE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && mem_addr == $past(mem_addr) + 8'd1)); // R4

  AST_READ_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && $past(st) == S_READ && mem_addr != $past(mem_addr))
      |-> (mem_addr == $past(mem_addr) + 8'd1)); // R7

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe); // R2

endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;

  localparam int Q = 8;
  localparam logic [15:0] VEC [8] = '{16'h003C, 16'hFFA5, 16'h1000, 16'h11FF,
                                      16'h7F81, 16'h807E, 16'h55AA, 16'hAA55};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b000;
  logic       sda_o, sda_oe, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       sda_bus;
  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  int n_tests = 0;
  int n_fail  = 0;
  int viol    = 0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus   = sda_m & ~(sda_oe & ~sda_o);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
    if (sda_oe && sda_o !== 1'b0) viol++;
  end

  i2c_regfile_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap_addr(strap),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qwait(1);
    scl_m = 1'b1; qwait(1);
    sda_m = 1'b0; qwait(1);
    scl_m = 1'b0; qwait(1);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait(1);
    scl_m = 1'b1; qwait(1);
    sda_m = 1'b1; qwait(1);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; qwait(2);
    scl_m = 1'b1; qwait(1);
    r = sda_bus; qwait(1);
    scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] v);
    logic ack;
    i2c_start();
    wr_byte(dev(strap, 1'b0), ack); chk("R1 dev ack", ack, 1);
    wr_byte(a, ack);                chk("R3 word addr ack", ack, 1);
    wr_byte(v, ack);                chk("R3 data ack", ack, 1);
    i2c_stop();
    ref_mem[a] = v;
  endtask

  task automatic do_rand_read(input logic [7:0] a, output logic [7:0] d);
    logic ack;
    i2c_start();
    wr_byte(dev(strap, 1'b0), ack); chk("R5 dev ack", ack, 1);
    wr_byte(a, ack);                chk("R5 word addr ack", ack, 1);
    i2c_start();
    wr_byte(dev(strap, 1'b1), ack); chk("R5 read dev ack", ack, 1);
    rd_byte(1'b0, d);
    i2c_stop();
  endtask

  task automatic do_cur_read(output logic [7:0] d);
    logic ack;
    i2c_start();
    wr_byte(dev(strap, 1'b1), ack); chk("R6 dev ack", ack, 1);
    rd_byte(1'b0, d);
    i2c_stop();
  endtask

  initial begin
    logic [7:0] d;
    logic ack, r;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (10) @(negedge clk);
    chk("R12 sda_oe in reset", sda_oe, 0);
    chk("R12 mem_we in reset", mem_we, 0);
    chk("R12 counter in reset", mem_addr, 0);
    rst_n = 1'b1;
    qwait(2);

    do_cur_read(d);
    chk("R6 R12 first current read", d, ref_mem[0]);

    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][15:8], VEC[i][7:0]);
      do_rand_read(VEC[i][15:8], d);
      chk("R3 R5 vector readback", d, VEC[i][7:0]);
    end

    do_write(8'h40, 8'h99);
    do_cur_read(d);
    chk("R6 R4 current read after write", d, ref_mem[8'h41]);

    i2c_start();
    wr_byte(dev(strap, 1'b0), ack);
    wr_byte(8'h80, ack);
    wr_byte(8'h11, ack); chk("R4 burst byte0 ack", ack, 1);
    wr_byte(8'h22, ack); chk("R4 burst byte1 ack", ack, 1);
    wr_byte(8'h33, ack); chk("R4 burst byte2 ack", ack, 1);
    i2c_stop();
    ref_mem[8'h80] = 8'h11; ref_mem[8'h81] = 8'h22; ref_mem[8'h82] = 8'h33;

    i2c_start();
    wr_byte(dev(strap, 1'b0), ack);
    wr_byte(8'h80, ack);
    i2c_start();
    wr_byte(dev(strap, 1'b1), ack);
    for (int i = 0; i < 3; i++) begin
      rd_byte(i != 2, d);
      chk("R7 R4 sequential burst", d, ref_mem[8'h80 + i]);
    end
    i2c_stop();

    i2c_start();
    wr_byte(dev(strap, 1'b0), ack);
    wr_byte(8'hFD, ack);
    i2c_start();
    wr_byte(dev(strap, 1'b1), ack);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] a;
      a = 8'hFD + 8'(i);
      rd_byte(i != 4, d);
      chk("R8 wrap read", d, ref_mem[a]);
    end
    qwait(1);
    chk("R9 released after NACK", sda_oe, 0);
    i2c_stop();
    qwait(1);
    chk("R9 released after STOP", sda_oe, 0);

    i2c_start();
    wr_byte(dev(3'b011, 1'b0), ack); chk("R2 mismatch no ack", ack, 0);
    wr_byte(8'h20, ack);             chk("R2 addr ignored", ack, 0);
    wr_byte(8'hEE, ack);             chk("R2 data ignored", ack, 0);
    i2c_stop();
    do_rand_read(8'h20, d);
    chk("R2 array unchanged", d, ref_mem[8'h20]);

    strap = 3'b101;
    i2c_start();
    wr_byte(dev(3'b000, 1'b0), ack); chk("R1 old strap rejected", ack, 0);
    i2c_stop();
    do_write(8'h66, 8'hC3);
    do_rand_read(8'h66, d);
    chk("R1 new strap works", d, 8'hC3);

    i2c_start();
    wr_byte(dev(strap, 1'b0), ack);
    wr_byte(8'h30, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
    i2c_stop();
    i2c_start();
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r);
    i2c_start();
    wr_byte(dev(strap, 1'b1), ack); chk("R11 ack after restart", ack, 1);
    rd_byte(1'b0, d);
    i2c_stop();
    chk("R11 partial byte not written", d, ref_mem[8'h30]);

    chk("R10 SDA only changed with SCL low", viol, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule